// File: doc/BRIEF.md
# Fixsliced AES MixColumns Unit

This block applies the AES MixColumns step to a 256-bit bitsliced state that carries two AES blocks at once. The state is split into eight 32-bit slices. Each slice gathers one bit position from every byte of both blocks. Because the surrounding datapath skips ShiftRows in most rounds, the column mixing has to absorb the missing row shifts. It does this with per-byte bit rotations whose amount depends on the round number modulo 4. A 2-bit variant input selects which of the four forms is applied.

The transform uses only XORs, masks, 32-bit word rotations and rotations of the bits inside each byte. One register stage sits behind it. A result is captured whenever `in_valid` is high and appears, flagged by `out_valid`, on the next clock edge. When `in_valid` is low the output register keeps its contents.

Top module: `fixslice_mixcol`

## Requirements
- R1: `out_valid` goes low as soon as `rst_n` is asserted (asynchronously) and stays low while reset is held. After reset, `out_valid` is high in exactly the cycle after a cycle with `in_valid` high and is low otherwise.
- R2: `state_out` takes the transform of `state_in` (under the sampled `variant`) one cycle after `in_valid` is high. While `in_valid` is low it keeps its value, whatever `state_in` and `variant` do.
- R3: Slice k sits at bits [32k+31:32k] of both `state_in` and `state_out` and holds bit 7-k of each of its four bytes. Byte j of a slice is at bits [8j+7:8j]. A word rotation by r moves slice bit i+r to bit i (modulo 32). A per-byte rotation by p moves byte bit (j+p) mod 8 to bit j.
- R4: For each input slice S_k three terms are formed. B_k is the per-byte rotation of S_k by p, followed by a word rotation by 8. A_k is S_k XOR B_k. C_k is the per-byte rotation of A_k by q, followed by a word rotation by 16. In this requirement q = 2p mod 8. Variant 0 uses p = 6 and q = 4; variant 2 uses p = 2 and q = 4.
- R5: Variant 1 uses p = 4 and q = 0, so no per-byte rotation is applied before the 16-bit word rotation.
- R6: Variant 3 uses p = 0 and q = 0, so only word rotations appear.
- R7: Output slice k, for k from 0 to 6, is A_(k+1) XOR B_k XOR C_k. Output slice 7 is A_0 XOR B_7 XOR C_7.
- R8: The term A_0 is also XORed into output slices 3, 4 and 6, and into no other slice besides slice 7.
- R9: The transform is linear for a fixed variant. An all-zero input gives an all-zero output, and the result for a XOR b equals the XOR of the results for a and b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for `state_in` and `variant` |
| variant | input | 2 | Round index modulo 4, selects the rotation form |
| state_in | input | 256 | Eight bitsliced 32-bit slices, slice k at bits [32k+31:32k] |
| out_valid | output | 1 | High in the cycle after a capture |
| state_out | output | 256 | Registered mixed state, same layout as the input |

## Verification
The hardest thing to observe at the ports is whether each variant applies the right inner and outer per-byte rotation amounts. With dense states, an error in one rotation hides among the many XOR terms. The stimulus therefore puts a single set bit in slice 7 under each variant. Only B_7, A_7 and C_7 are then nonzero, so the inner rotation shows up directly in output slice 6, and the outer rotation in output slice 7. A byte-wide pattern in slice 0 isolates the fold of A_0 into slices 3, 4, 6 and 7. Dense pseudo-random states for every variant are then compared against a bit-loop model, and a linearity check is made on the outputs of the design.

// File: rtl/fsmc_pkg.sv
package fsmc_pkg;

  parameter int unsigned LANES          = 8;
  parameter int unsigned LANE_W         = 32;
  parameter int unsigned BYTE_W         = 8;
  parameter int unsigned VAR_W          = 2;
  localparam int unsigned BYTES_PER_LANE = LANE_W / BYTE_W;
  localparam int unsigned STATE_W        = LANES * LANE_W;
  localparam int unsigned NUM_VAR        = 1 << VAR_W;

  // Output lanes that also receive the reduction term of lane 0.
  localparam logic [LANES-1:0] FOLD_MASK = 8'b0101_1000;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [VAR_W-1:0]  variant_t;

  // Replicate one byte across a lane.
  function automatic lane_t rep_byte(logic [BYTE_W-1:0] b);
    lane_t r;
    for (int i = 0; i < BYTES_PER_LANE; i++) r[i*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  // Rotate a lane right by k bit positions.
  function automatic lane_t word_ror(lane_t x, int unsigned k);
    return (x >> k) | (x << (LANE_W - k));
  endfunction

  // Inner per-byte rotation for a variant: 6, 4, 2, 0.
  function automatic int unsigned inner_amt(int unsigned v);
    return (BYTE_W - 2 - 2 * v) % BYTE_W;
  endfunction

  // Outer per-byte rotation: twice the inner amount, modulo a byte.
  function automatic int unsigned outer_amt(int unsigned v);
    return (2 * inner_amt(v)) % BYTE_W;
  endfunction

endpackage

// File: rtl/fsmc_rst_sync.sv
module fsmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsmc_byte_rot.sv
module fsmc_byte_rot import fsmc_pkg::*; #(
  parameter int unsigned AMT = 0
) (
  input  lane_t din,
  output lane_t dout
);

  // Bits that slide down inside each byte, and bits that wrap to the top.
  localparam logic [BYTE_W-1:0] DOWN_KEEP = {BYTE_W{1'b1}} >> AMT;
  localparam logic [BYTE_W-1:0] WRAP_KEEP = {BYTE_W{1'b1}} >> (BYTE_W - AMT);
  localparam lane_t       DOWN_MASK = rep_byte(DOWN_KEEP);
  localparam lane_t       WRAP_MASK = rep_byte(WRAP_KEEP);
  localparam int unsigned UP_SHIFT  = (BYTE_W - AMT) % BYTE_W;

  assign dout = ((din >> AMT) & DOWN_MASK) | ((din & WRAP_MASK) << UP_SHIFT);

endmodule

// File: rtl/fsmc_lane_terms.sv
module fsmc_lane_terms import fsmc_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  variant_t variant,
  input  lane_t    lane_in,
  output lane_t    shifted_term,
  output lane_t    mixed_term,
  output lane_t    swapped_term
);

  lane_t inner_rot [NUM_VAR];
  lane_t shifted_v [NUM_VAR];
  lane_t mixed_v   [NUM_VAR];
  lane_t outer_rot [NUM_VAR];
  lane_t swapped_v [NUM_VAR];

  for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
    fsmc_byte_rot #(.AMT(inner_amt(v))) u_inner (
      .din  (lane_in),
      .dout (inner_rot[v])
    );

    assign shifted_v[v] = word_ror(inner_rot[v], BYTE_W);
    assign mixed_v[v]   = lane_in ^ shifted_v[v];

    fsmc_byte_rot #(.AMT(outer_amt(v))) u_outer (
      .din  (mixed_v[v]),
      .dout (outer_rot[v])
    );

    assign swapped_v[v] = word_ror(outer_rot[v], 2 * BYTE_W);

    // A byte rotation only moves bits: the set-bit count must not change.
    assert_rot_keeps_bits_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      $countones(inner_rot[v]) == $countones(lane_in)
    ) else $error("per-byte rotation lost or gained bits");
  end

  always_comb begin
    shifted_term = shifted_v[variant];
    mixed_term   = mixed_v[variant];
    swapped_term = swapped_v[variant];
  end

endmodule

// File: rtl/fsmc_combine.sv
module fsmc_combine import fsmc_pkg::*; (
  input  lane_t mixed     [LANES],
  input  lane_t shifted   [LANES],
  input  lane_t swapped   [LANES],
  output lane_t lanes_out [LANES]
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned NEIGH = (k + 1) % LANES;
    if (FOLD_MASK[k]) begin : g_fold
      assign lanes_out[k] = mixed[NEIGH] ^ shifted[k] ^ swapped[k] ^ mixed[0];
    end else begin : g_plain
      assign lanes_out[k] = mixed[NEIGH] ^ shifted[k] ^ swapped[k];
    end
  end

endmodule

// File: rtl/fixslice_mixcol.sv
module fixslice_mixcol import fsmc_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VAR_W-1:0]   variant,
  input  logic [STATE_W-1:0] state_in,
  output logic               out_valid,
  output logic [STATE_W-1:0] state_out
);

  logic rst_sync_n;

  fsmc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lane_t lanes_in  [LANES];
  lane_t shifted   [LANES];
  lane_t mixed     [LANES];
  lane_t swapped   [LANES];
  lane_t lanes_mix [LANES];
  logic [STATE_W-1:0] mix_state;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes_in[k] = state_in[k*LANE_W +: LANE_W];

    fsmc_lane_terms u_terms (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .variant      (variant),
      .lane_in      (lanes_in[k]),
      .shifted_term (shifted[k]),
      .mixed_term   (mixed[k]),
      .swapped_term (swapped[k])
    );

    assign mix_state[k*LANE_W +: LANE_W] = lanes_mix[k];
  end

  fsmc_combine u_combine (
    .mixed     (mixed),
    .shifted   (shifted),
    .swapped   (swapped),
    .lanes_out (lanes_mix)
  );

  logic               valid_q, valid_d;
  logic [STATE_W-1:0] state_q, state_d;

  always_comb begin
    valid_d = in_valid;
    state_d = state_q;
    if (in_valid) state_d = mix_state;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) state_q <= state_d;
  end

  assign out_valid = valid_q;
  assign state_out = state_q;

  assert_valid_rise_R1: assert property (
    @(posedge clk) disable iff (!rst_sync_n) in_valid |=> out_valid
  ) else $error("out_valid missing after capture");

  assert_valid_idle_R1: assert property (
    @(posedge clk) disable iff (!rst_sync_n) !in_valid |=> !out_valid
  ) else $error("out_valid without capture");

  assert_hold_state_R2: assert property (
    @(posedge clk) disable iff (!rst_sync_n) !in_valid |=> $stable(state_out)
  ) else $error("state_out changed without capture");

  assert_zero_map_R9: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (in_valid && state_in == '0) |=> state_out == '0
  ) else $error("zero state did not map to zero");

endmodule

// File: tb/fixslice_mixcol_bench.sv
module fixslice_mixcol_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   variant;
  logic [255:0] state_in;
  logic         out_valid;
  logic [255:0] state_out;

  always #4 clk = ~clk;

  fixslice_mixcol u_fixslice_mixcol (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .variant   (variant),
    .state_in  (state_in),
    .out_valid (out_valid),
    .state_out (state_out)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  localparam int NV = 6;
  localparam logic [1:0] VT_VAR [NV] = '{2'd3, 2'd1, 2'd0, 2'd2, 2'd3, 2'd0};
  localparam logic [255:0] VT_IN [NV] = '{
    256'h0000_00FF,
    {32'h0000_0001, 224'h0},
    {32'h0000_0001, 224'h0},
    {32'h0000_0001, 224'h0},
    256'h0,
    {256{1'b1}}
  };
  localparam logic [255:0] VT_EXP [NV] = '{
    {32'hFF0000FF, 32'hFF0000FF, 32'h0, 32'hFF0000FF, 32'hFF0000FF, 32'h0, 32'h0, 32'hFFFFFF00},
    {32'h10011000, 32'h10000001, 192'h0},
    {32'h04104000, 32'h04000001, 192'h0},
    {32'h40100400, 32'h40000001, 192'h0},
    256'h0,
    256'h0
  };
  localparam bit VT_HAS [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam string VT_TAG [NV] = '{"R6 R8", "R5", "R4", "R4", "R9", "R7"};

  function automatic logic [31:0] m_brot(logic [31:0] x, int p);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 8; j++)
        r[8*b + j] = x[8*b + ((j + p) % 8)];
    return r;
  endfunction

  function automatic logic [31:0] m_wrot(logic [31:0] x, int k);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = x[(j + k) % 32];
    return r;
  endfunction

  function automatic logic [255:0] model(logic [1:0] v, logic [255:0] s);
    logic [31:0] sl [8];
    logic [31:0] aa [8];
    logic [31:0] bb [8];
    logic [31:0] cc [8];
    logic [255:0] o;
    int p, q;
    case (v)
      2'd0:    p = 6;
      2'd1:    p = 4;
      2'd2:    p = 2;
      default: p = 0;
    endcase
    q = (2 * p) % 8;
    for (int k = 0; k < 8; k++) begin
      sl[k] = s[32*k +: 32];
      bb[k] = m_wrot(m_brot(sl[k], p), 8);
      aa[k] = sl[k] ^ bb[k];
      cc[k] = m_wrot(m_brot(aa[k], q), 16);
    end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      w = (k == 7) ? aa[0] : aa[k+1];
      w = w ^ bb[k] ^ cc[k];
      if (k == 3 || k == 4 || k == 6) w = w ^ aa[0];
      o[32*k +: 32] = w;
    end
    return o;
  endfunction

  logic [31:0] seed = 32'h1badcafe;
  function automatic logic [31:0] next_word(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic rand_state(output logic [255:0] s);
    for (int k = 0; k < 8; k++) begin
      seed = next_word(seed);
      s[32*k +: 32] = seed;
    end
  endtask

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic apply(input logic [1:0] v, input logic [255:0] s, output logic [255:0] got);
    @(negedge clk);
    in_valid = 1'b1;
    variant  = v;
    state_in = s;
    @(negedge clk);
    in_valid = 1'b0;
    got = state_out;
    check("R1 out_valid after capture", {255'h0, out_valid}, 256'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [255:0] got, ga, gb, gx, sa, sb, held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    variant  = 2'd0;
    state_in = '0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {255'h0, out_valid}, 256'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {255'h0, out_valid}, 256'h0);

    // Vector table: single-bit and pattern stimuli (R3 layout, R4-R9).
    for (int i = 0; i < NV; i++) begin
      apply(VT_VAR[i], VT_IN[i], got);
      if (VT_HAS[i]) check({VT_TAG[i], " table R3"}, got, VT_EXP[i]);
      else           check({VT_TAG[i], " table model"}, got, model(VT_VAR[i], VT_IN[i]));
    end

    // Dense states under every variant: R4 R5 R6 R7 R8.
    for (int v = 0; v < 4; v++) begin
      for (int n = 0; n < 10; n++) begin
        rand_state(sa);
        apply(v[1:0], sa, got);
        check("R7 R8 dense state", got, model(v[1:0], sa));
      end
    end

    // Linearity over the outputs of the design: R9.
    for (int v = 0; v < 4; v++) begin
      rand_state(sa);
      rand_state(sb);
      apply(v[1:0], sa, ga);
      apply(v[1:0], sb, gb);
      apply(v[1:0], sa ^ sb, gx);
      check("R9 linearity", gx, ga ^ gb);
    end

    // Back-to-back captures: out_valid stays high, each result lands: R1 R2.
    rand_state(sa);
    rand_state(sb);
    @(negedge clk);
    in_valid = 1'b1; variant = 2'd1; state_in = sa;
    @(negedge clk);
    variant = 2'd2; state_in = sb;
    check("R2 first of pair", state_out, model(2'd1, sa));
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid second of pair", {255'h0, out_valid}, 256'h1);
    check("R2 second of pair", state_out, model(2'd2, sb));
    @(negedge clk);
    check("R1 out_valid drops", {255'h0, out_valid}, 256'h0);

    // Hold while idle with changing inputs: R2.
    rand_state(sa);
    apply(2'd3, sa, held);
    for (int n = 0; n < 4; n++) begin
      rand_state(sb);
      state_in = sb;
      variant  = n[1:0];
      @(negedge clk);
      check("R2 hold when idle", state_out, held);
      check("R1 idle out_valid", {255'h0, out_valid}, 256'h0);
    end

    // Reset in mid-run: out_valid clears at once, then operation resumes: R1.
    @(negedge clk);
    in_valid = 1'b1; state_in = sa; variant = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears out_valid", {255'h0, out_valid}, 256'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 still low after release", {255'h0, out_valid}, 256'h0);
    rand_state(sa);
    apply(2'd0, sa, got);
    check("R4 after reset", got, model(2'd0, sa));

    done = 1'b1;
    finish_run();
  end

endmodule